// File: doc/BRIEF.md
# Shared-Line Fixed-Vector Interrupt Controller

This block is a single eight-line interrupt controller for an 8086-class processor bus. It latches hardware requests, picks the most urgent one by fixed priority, raises `intr`, and answers an interrupt-acknowledge strobe with a vector byte. Lines other than the shared line return the programmed vector base plus the line number. There is no cascading, no poll mode and no special nesting mode.

Line 1 is a shared line. Three sources drive it: two serial receive ports, each handing over a byte, and a real-time-clock alarm. A bus device may also hold the line. Whatever base is programmed, line 1 always returns vector 0x71. Software then reads a source-status register to see which source asked for service. Each serial byte is held in its own data register. The alarm source can be masked on its own.

A small register file is reached through `io_addr`, with `io_wr`/`io_rd` strobes. It holds the vector base (readable in bits 7:3), the line mask, the in-service bits, a non-specific end-of-interrupt command, the source status, the alarm mask and an alarm-acknowledge command.

Top module: `shirq_ctrl`

## Requirements
- R1: After reset `intr` is 0, `vec_valid` is 0, and the base, line mask, in-service, source status and alarm-mask registers all read 0.
- R2: For a line n other than 1, the vector is {base, n}. The base is written through `io_wdata[7:3]` at address 0.
- R3: The vector for line 1 is always 0x71, whatever base is programmed.
- R4: Line 1 requests while any of these holds: serial port 1 status, serial port 2 status, an unmasked alarm status, or `irq_lines[1]`. At address 3, bit 2 reads the port-1 status, bit 3 the port-2 status and bit 4 the alarm status.
- R5: Bit 0 of the alarm-mask register (address 4) gates the alarm. With the bit at 1, a pending alarm does not request line 1. With the bit at 0, it does.
- R6: Reading address 5 (port 1 data) clears the port-1 status, and reading address 6 (port 2 data) clears the port-2 status. Any write to address 3 clears the alarm status.
- R7: Priority is fixed, with line 0 the highest. A pending line is offered only if no line of equal or higher priority is in service.
- R8: A line whose bit is 1 in the line mask (address 1) raises no `intr`. Clearing the bit lets its held request through.
- R9: Any write to address 2 clears the lowest-numbered set in-service bit. Address 2 reads the in-service bits.
- R10: A read of address 0 returns the base in bits 7:3, with bits 2:0 at 0.
- R11: Lines other than 1 latch a rising edge until they are acknowledged. A line held high after its acknowledge does not request again.
- R12: A one-cycle `inta` while `intr` is high sets the granted in-service bit. On the next cycle it gives a one-cycle `vec_valid` with the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_lines | input | 8 | Hardware request lines; bit 1 joins the shared line |
| sp1_valid | input | 1 | Serial port 1 byte strobe |
| sp1_data | input | 8 | Serial port 1 byte |
| sp2_valid | input | 1 | Serial port 2 byte strobe |
| sp2_data | input | 8 | Serial port 2 byte |
| alarm_pulse | input | 1 | Real-time-clock alarm event |
| io_addr | input | 3 | Register address |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe (for clear-on-read) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from `io_addr` |
| intr | output | 1 | Interrupt request to processor |
| inta | input | 1 | Interrupt acknowledge strobe |
| vec_valid | output | 1 | Vector byte valid |
| vec_out | output | 8 | Vector byte |

## Verification
An edge on a line, or a serial or alarm strobe, is latched at the next clock edge, so `intr` is due one cycle after the stimulus. The bench drives on falling edges and samples on the following falling edge. The vector and `vec_valid` are due one cycle after `inta`, and the bench samples them at the falling edge right after that strobe. Register effects and status clears appear one cycle after the strobe. Read data is combinational, so it is sampled while the read strobe is still held, before the edge that clears it.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
   typedef enum logic [2:0] {
      RA_BASE  = 3'd0,
      RA_LMASK = 3'd1,
      RA_CMD   = 3'd2,
      RA_SRC   = 3'd3,
      RA_XMASK = 3'd4,
      RA_SP1   = 3'd5,
      RA_SP2   = 3'd6
   } reg_addr_e;

   localparam int STAT_SP1_BIT = 2;
   localparam int STAT_SP2_BIT = 3;
   localparam int STAT_ALM_BIT = 4;
   localparam int NUM_PORTS    = 2;
endpackage

// File: rtl/shirq_src.sv
module shirq_src #(
   parameter int DW    = 8,
   parameter int NPORT = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPORT-1:0]         port_valid,
   input  logic [NPORT-1:0][DW-1:0] port_data,
   input  logic [NPORT-1:0]         port_rd,
   input  logic                     alarm_pulse,
   input  logic                     alarm_ack,
   input  logic                     alarm_mask,
   input  logic                     bus_share,
   output logic [NPORT-1:0][DW-1:0] port_q,
   output logic [NPORT-1:0]         port_st,
   output logic                     alarm_st,
   output logic                     shared_req
);
   initial begin
      assert (NPORT >= 1) else $error("shirq_src: NPORT must be at least 1");
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            port_st[p] <= 1'b0;
            port_q[p]  <= '0;
         end else if (port_valid[p]) begin
            port_st[p] <= 1'b1;
            port_q[p]  <= port_data[p];
         end else if (port_rd[p]) begin
            port_st[p] <= 1'b0;
         end
      end

      // R6: a data read with no new byte clears the port status
      a_r6_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
         port_rd[p] && !port_valid[p] |=> !port_st[p]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           alarm_st <= 1'b0;
      else if (alarm_pulse) alarm_st <= 1'b1;
      else if (alarm_ack)   alarm_st <= 1'b0;
   end

   assign shared_req = (|port_st) | (alarm_st & ~alarm_mask) | bus_share;
endmodule

// File: rtl/shirq_req.sv
module shirq_req #(
   parameter int N      = 8,
   parameter int SHARED = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_lines,
   input  logic         shared_req,
   input  logic [N-1:0] ack_clr,
   output logic [N-1:0] irr
);
   for (genvar i = 0; i < N; i++) begin : g_line
      if (i == SHARED) begin : g_level
         logic unused_ack;
         assign unused_ack = ack_clr[i] | irq_lines[i];
         assign irr[i] = shared_req;
      end else begin : g_edge
         logic prev_q, irr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               irr_q  <= 1'b0;
            end else begin
               prev_q <= irq_lines[i];
               if (irq_lines[i] && !prev_q) irr_q <= 1'b1;
               else if (ack_clr[i])         irr_q <= 1'b0;
            end
         end
         assign irr[i] = irr_q;
      end
   end
endmodule

// File: rtl/shirq_prio.sv
module shirq_prio #(
   parameter int N  = 8,
   parameter int LW = $clog2(N)
) (
   input  logic [N-1:0]  irr,
   input  logic [N-1:0]  imr,
   input  logic [N-1:0]  isr,
   output logic          intr,
   output logic [LW-1:0] grant
);
   logic [N-1:0] req;
   logic         stop;

   assign req = irr & ~imr;

   always_comb begin
      grant = '0;
      intr  = 1'b0;
      stop  = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!stop) begin
            if (isr[i]) begin
               stop = 1'b1;
            end else if (req[i]) begin
               grant = LW'(i);
               intr  = 1'b1;
               stop  = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/shirq_ctrl.sv
module shirq_ctrl
   import shirq_pkg::*;
#(
   parameter int           NUM_LINES   = 8,
   parameter int           DW          = 8,
   parameter int           SHARED_LINE = 1,
   parameter logic [7:0]   FIXED_VEC   = 8'h71
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 sp1_valid,
   input  logic [DW-1:0]        sp1_data,
   input  logic                 sp2_valid,
   input  logic [DW-1:0]        sp2_data,
   input  logic                 alarm_pulse,
   input  logic [2:0]           io_addr,
   input  logic                 io_wr,
   input  logic                 io_rd,
   input  logic [DW-1:0]        io_wdata,
   output logic [DW-1:0]        io_rdata,
   output logic                 intr,
   input  logic                 inta,
   output logic                 vec_valid,
   output logic [DW-1:0]        vec_out
);
   localparam int LW = $clog2(NUM_LINES);
   localparam int BW = DW - LW;

   initial begin
      assert (SHARED_LINE < NUM_LINES) else $error("shirq_ctrl: shared line out of range");
      assert (NUM_LINES <= DW)         else $error("shirq_ctrl: lines exceed data width");
      assert (DW == 8)                 else $error("shirq_ctrl: vector bus is 8 bits");
      assert (BW > 0)                  else $error("shirq_ctrl: no room for base");
   end

   reg_addr_e ra;
   assign ra = reg_addr_e'(io_addr);

   logic [BW-1:0]        base_q;
   logic [NUM_LINES-1:0] imr_q, isr_q, irr, ack_clr;
   logic                 xmask_q;
   logic [LW-1:0]        grant;
   logic                 ack, eoi_wr;
   logic [DW-1:0]        vec_d;

   logic [NUM_PORTS-1:0]         pv, prd, pst;
   logic [NUM_PORTS-1:0][DW-1:0] pdat, pq;
   logic                         alarm_st, shared_req;

   assign pv   = {sp2_valid, sp1_valid};
   assign pdat = {sp2_data, sp1_data};
   assign prd[0] = io_rd && (ra == RA_SP1);
   assign prd[1] = io_rd && (ra == RA_SP2);

   shirq_src #(.DW(DW), .NPORT(NUM_PORTS)) u_src (
      .clk(clk), .rst_n(rst_n),
      .port_valid(pv), .port_data(pdat), .port_rd(prd),
      .alarm_pulse(alarm_pulse),
      .alarm_ack(io_wr && (ra == RA_SRC)),
      .alarm_mask(xmask_q),
      .bus_share(irq_lines[SHARED_LINE]),
      .port_q(pq), .port_st(pst),
      .alarm_st(alarm_st), .shared_req(shared_req)
   );

   shirq_req #(.N(NUM_LINES), .SHARED(SHARED_LINE)) u_req (
      .clk(clk), .rst_n(rst_n),
      .irq_lines(irq_lines), .shared_req(shared_req),
      .ack_clr(ack_clr), .irr(irr)
   );

   shirq_prio #(.N(NUM_LINES), .LW(LW)) u_prio (
      .irr(irr), .imr(imr_q), .isr(isr_q),
      .intr(intr), .grant(grant)
   );

   assign ack     = inta && intr;
   assign ack_clr = ack ? (NUM_LINES'(1) << grant) : '0;
   assign eoi_wr  = io_wr && (ra == RA_CMD);

   always_comb begin
      if (!intr)                         vec_d = {base_q, LW'(NUM_LINES - 1)};
      else if (grant == LW'(SHARED_LINE)) vec_d = FIXED_VEC;
      else                               vec_d = {base_q, grant};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q    <= '0;
         imr_q     <= '0;
         xmask_q   <= 1'b0;
         isr_q     <= '0;
         vec_out   <= '0;
         vec_valid <= 1'b0;
      end else begin
         if (io_wr && ra == RA_BASE)  base_q  <= io_wdata[DW-1:LW];
         if (io_wr && ra == RA_LMASK) imr_q   <= io_wdata[NUM_LINES-1:0];
         if (io_wr && ra == RA_XMASK) xmask_q <= io_wdata[0];
         isr_q     <= (eoi_wr ? (isr_q & (isr_q - NUM_LINES'(1))) : isr_q) | ack_clr;
         vec_valid <= inta;
         if (inta) vec_out <= vec_d;
      end
   end

   always_comb begin
      io_rdata = '0;
      case (ra)
         RA_BASE:  io_rdata = {base_q, LW'(0)};
         RA_LMASK: io_rdata = DW'(imr_q);
         RA_CMD:   io_rdata = DW'(isr_q);
         RA_SRC: begin
            io_rdata[STAT_SP1_BIT] = pst[0];
            io_rdata[STAT_SP2_BIT] = pst[1];
            io_rdata[STAT_ALM_BIT] = alarm_st;
         end
         RA_XMASK: io_rdata = DW'(xmask_q);
         RA_SP1:   io_rdata = pq[0];
         RA_SP2:   io_rdata = pq[1];
         default:  io_rdata = '0;
      endcase
   end

   // R3: an acknowledged shared line yields the fixed vector
   a_r3_fixed_vec : assert property (@(posedge clk) disable iff (!rst_n)
      inta && intr && grant == LW'(SHARED_LINE) |=> vec_out == FIXED_VEC);
   // R8: a granted line is never masked
   a_r8_grant_unmasked : assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> !imr_q[grant]);
   // R12: an acknowledge adds exactly one in-service bit
   a_r12_ack_sets_one : assert property (@(posedge clk) disable iff (!rst_n)
      ack && !eoi_wr |=> $countones(isr_q) == $countones($past(isr_q)) + 1);
   // R9: an end-of-interrupt removes exactly one in-service bit
   a_r9_eoi_clears_one : assert property (@(posedge clk) disable iff (!rst_n)
      eoi_wr && !ack && isr_q != '0 |=> $countones(isr_q) + 1 == $countones($past(isr_q)));
   // R12: vector strobe follows the acknowledge
   a_r12_vec_follows : assert property (@(posedge clk) disable iff (!rst_n)
      inta |=> vec_valid);
endmodule

// File: tb/test_shirq_ctrl.sv
`timescale 1ns/1ps
module test_shirq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_lines = '0;
   logic       sp1_valid = 0, sp2_valid = 0, alarm_pulse = 0;
   logic [7:0] sp1_data = '0, sp2_data = '0;
   logic [2:0] io_addr = '0;
   logic       io_wr = 0, io_rd = 0, inta = 0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata, vec_out;
   logic       intr, vec_valid;

   int checks = 0;
   int fails  = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   shirq_ctrl i_shirq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
      .sp1_valid(sp1_valid), .sp1_data(sp1_data),
      .sp2_valid(sp2_valid), .sp2_data(sp2_data),
      .alarm_pulse(alarm_pulse), .io_addr(io_addr), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .intr(intr), .inta(inta), .vec_valid(vec_valid), .vec_out(vec_out)
   );

   // line(3) base(5) expected vector(8)
   localparam logic [15:0] TBL [7] = '{
      {3'd0, 5'h02, 8'h10}, {3'd3, 5'h02, 8'h13}, {3'd7, 5'h1F, 8'hFF},
      {3'd1, 5'h02, 8'h71}, {3'd1, 5'h1F, 8'h71}, {3'd6, 5'h0E, 8'h76},
      {3'd2, 5'h0E, 8'h72}};

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
      @(negedge clk); io_wr = 0;
   endtask

   task automatic rd(logic [2:0] a, output logic [7:0] d);
      @(negedge clk); io_addr = a; io_rd = 1;
      #0.5 d = io_rdata;
      @(negedge clk); io_rd = 0;
   endtask

   task automatic ack(output logic [7:0] v, output logic vv);
      @(negedge clk); inta = 1;
      @(negedge clk); inta = 0; v = vec_out; vv = vec_valid;
   endtask

   task automatic raise(int n);
      @(negedge clk); irq_lines[n] = 1;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, v;
      logic vv;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 intr", {7'b0, intr}, 8'h00);
      check("R1 vec_valid", {7'b0, vec_valid}, 8'h00);
      rd(3'd0, d); check("R1 base", d, 8'h00);
      rd(3'd1, d); check("R1 line mask", d, 8'h00);
      rd(3'd2, d); check("R1 in-service", d, 8'h00);
      rd(3'd3, d); check("R1 status", d, 8'h00);
      rd(3'd4, d); check("R1 alarm mask", d, 8'h00);

      // table walk: R2 / R3 / R12
      for (int k = 0; k < 7; k++) begin
         int ln;
         ln = int'(TBL[k][15:13]);
         wr(3'd0, {TBL[k][12:8], 3'b000});
         if (ln == 1) begin
            @(negedge clk); sp1_valid = 1; sp1_data = 8'h30 + 8'(k);
            @(negedge clk); sp1_valid = 0;
         end else begin
            raise(ln);
         end
         check("R11 intr on request", {7'b0, intr}, 8'h01);
         ack(v, vv);
         check("R12 vec_valid", {7'b0, vv}, 8'h01);
         check(ln == 1 ? "R3 shared vector" : "R2 base+line vector", v, TBL[k][7:0]);
         @(negedge clk);
         check("R12 vec_valid one cycle", {7'b0, vec_valid}, 8'h00);
         irq_lines = '0;
         if (ln == 1) begin
            rd(3'd5, d); check("R6 port1 data", d, 8'h30 + 8'(k));
         end
         rd(3'd2, d); check("R12 in-service set", d, 8'(1) << ln);
         wr(3'd2, 8'h00);
         rd(3'd2, d); check("R9 in-service cleared", d, 8'h00);
         check("R11 no request left", {7'b0, intr}, 8'h00);
      end

      // R10 base readback
      wr(3'd0, 8'hAB);
      rd(3'd0, d); check("R10 base readback", d, 8'hA8);

      // R7 priority and nesting, R11 held line does not re-request
      @(negedge clk); irq_lines[5] = 1; irq_lines[3] = 1;
      @(negedge clk);
      ack(v, vv); check("R7 higher priority wins", v, 8'hAB);
      check("R7 blocked by in-service", {7'b0, intr}, 8'h00);
      raise(0);
      check("R7 higher line preempts", {7'b0, intr}, 8'h01);
      ack(v, vv); check("R7 preempt vector", v, 8'hA8);
      rd(3'd2, d); check("R12 nested in-service", d, 8'h09);
      wr(3'd2, 8'h00);
      rd(3'd2, d); check("R9 lowest bit cleared first", d, 8'h08);
      wr(3'd2, 8'h00);
      check("R7 pending line offered", {7'b0, intr}, 8'h01);
      ack(v, vv); check("R7 lower line vector", v, 8'hAD);
      wr(3'd2, 8'h00);
      check("R11 held lines no re-request", {7'b0, intr}, 8'h00);
      irq_lines = '0;

      // R8 line mask
      wr(3'd1, 8'h10);
      raise(4);
      check("R8 masked line", {7'b0, intr}, 8'h00);
      wr(3'd1, 8'h00);
      check("R8 unmasked line", {7'b0, intr}, 8'h01);
      ack(v, vv); check("R8 vector", v, 8'hAC);
      wr(3'd2, 8'h00); irq_lines = '0;

      // R4 / R6 port 2
      @(negedge clk); sp2_valid = 1; sp2_data = 8'hA5;
      @(negedge clk); sp2_valid = 0;
      rd(3'd3, d); check("R4 port2 status bit3", d, 8'h08);
      check("R4 port2 requests", {7'b0, intr}, 8'h01);
      rd(3'd6, d); check("R6 port2 data", d, 8'hA5);
      rd(3'd3, d); check("R6 port2 status cleared", d, 8'h00);
      check("R6 no request after read", {7'b0, intr}, 8'h00);

      // R5 / R6 alarm
      wr(3'd4, 8'h01);
      @(negedge clk); alarm_pulse = 1;
      @(negedge clk); alarm_pulse = 0;
      rd(3'd3, d); check("R4 alarm status bit4", d, 8'h10);
      check("R5 masked alarm", {7'b0, intr}, 8'h00);
      wr(3'd4, 8'h00);
      check("R5 unmasked alarm", {7'b0, intr}, 8'h01);
      ack(v, vv); check("R3 alarm vector", v, 8'h71);
      wr(3'd3, 8'h00);
      rd(3'd3, d); check("R6 alarm acknowledged", d, 8'h00);
      wr(3'd2, 8'h00);
      check("R6 alarm request gone", {7'b0, intr}, 8'h00);

      // R4 bus line 1 share
      raise(1);
      check("R4 bus line 1 requests", {7'b0, intr}, 8'h01);
      rd(3'd3, d); check("R4 no port status from bus line", d, 8'h00);
      ack(v, vv); check("R3 bus line vector", v, 8'h71);
      irq_lines = '0;
      wr(3'd2, 8'h00);
      check("R4 bus line released", {7'b0, intr}, 8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule